// File: doc/BRIEF.md
# Three-Level Cascaded Interrupt Aggregator

This block collects interrupt events from three tiers of sources and folds them into one processor request line. At the bottom sit a number of DMA channels. Each channel has a small flag register and a matching enable mask. Whenever a channel has a flag that is both raised and enabled, that channel holds one fixed bit high in a 32-bit peripheral pending register.

The peripheral pending register has an enable mask of its own. If any of its enabled bits is high, a dedicated cascade bit in the 32-bit system pending register is held high. The processor request is the registered OR of the system pending bits that the system mask enables.

Software reaches every register through a simple single-cycle read/write port. Hardware sources raise bits through set vectors, and a set always beats a software clear that arrives in the same cycle. The only way to clear the periodic-timer bit of the system pending register is a write to a timer control address with a key bit set.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, every pending, mask and flag register reads zero and `cpu_irq` is low.
- R2: `cpu_irq` is high in the cycle after one in which the AND of system pending and system mask is nonzero, and low in the cycle after one in which it is zero.
- R3: The system mask (address 0x04) reads back the value last written. Bus writes to the system pending register (address 0x00) have no effect.
- R4: A 1 on `sys_set[i]` sets system pending bit i, and the bit stays set. Bit 24 is the exception: `sys_set[24]` is ignored.
- R5: A write to the timer control address 0x08 with data bit 7 set clears system pending bit 30. A write with bit 7 clear changes nothing.
- R6: System pending bit 24 is high exactly when the AND of peripheral pending and peripheral mask is nonzero.
- R7: A 1 on `per_set[i]` sets peripheral pending bit i, and the bit stays set. A bus write to address 0x10 clears every peripheral pending bit that is 1 in the written data. A write to the peripheral mask (address 0x14) replaces it.
- R8: The channel flag register holds three flags in bits 2:0, and channel c's flags arrive on `dma_set[3c+2:3c]`. Flags are sticky and are cleared by writing ones to the flag address (0x20 + 8c). The channel mask at 0x24 + 8c keeps only bits 2:0 of the written data. Reads return these registers zero-extended.
- R9: Channel 0 drives peripheral pending bit 21 and channel 1 drives bit 20. The bit is high exactly while the AND of that channel's flags and mask is nonzero. `per_set` and bus clears do not affect these bits.
- R10: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. Reads of unmapped addresses return zero, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_set | input | 32 | Hardware set pulses into system pending |
| per_set | input | 32 | Hardware set pulses into peripheral pending |
| dma_set | input | 6 | Channel flag set pulses, 3 per channel |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
Two things can land in the same cycle on the same bit: a hardware set and a software clear. This applies to the timer bit of the system pending register, to a peripheral pending bit, and to a channel flag. The bench drives each pairing in a single cycle, with the set vector pulsed during the very bus write that carries the clear. It then reads the register back and expects the bit to remain set. The cascade path is also judged for timing: `cpu_irq` is sampled both in the cycle right after a mask or pending change and one cycle later, so that exactly one register of delay is confirmed.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

   // Register byte addresses (8-bit map)
   localparam logic [7:0] A_SYS_PEND   = 8'h00;
   localparam logic [7:0] A_SYS_MASK   = 8'h04;
   localparam logic [7:0] A_PIT_CTRL   = 8'h08;
   localparam logic [7:0] A_PER_PEND   = 8'h10;
   localparam logic [7:0] A_PER_MASK   = 8'h14;
   localparam logic [7:0] A_CH_BASE    = 8'h20;
   localparam logic [7:0] A_CH_STRIDE  = 8'h08;
   localparam logic [7:0] A_CH_MASK_OF = 8'h04;

   function automatic logic [7:0] ch_flag_addr(input int c);
      return A_CH_BASE + 8'(c) * A_CH_STRIDE;
   endfunction

   function automatic logic [7:0] ch_mask_addr(input int c);
      return A_CH_BASE + 8'(c) * A_CH_STRIDE + A_CH_MASK_OF;
   endfunction

endpackage

// File: rtl/irq_pend_level.sv
// One pending/mask stage: sticky bits with hardware set and software clear
// (set wins), plus bits that simply follow a level input.
module irq_pend_level #(
   parameter int             W          = 32,
   parameter logic [W-1:0]   LEVEL_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] sw_clr,
   input  logic [W-1:0] level_in,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wdata,
   output logic [W-1:0] pend,
   output logic [W-1:0] mask,
   output logic         any_hit
);

   logic [W-1:0] sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         mask     <= '0;
      end else begin
         sticky_q <= ((sticky_q & ~sw_clr) | hw_set) & ~LEVEL_MASK;
         if (mask_we) mask <= mask_wdata;
      end
   end

   assign pend    = (sticky_q & ~LEVEL_MASK) | (level_in & LEVEL_MASK);
   assign any_hit = |(pend & mask);

endmodule

// File: rtl/irq_dma_chan.sv
// Per-channel flag register (write-one-to-clear, set wins) and enable mask.
module irq_dma_chan #(
   parameter int FLAGS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLAGS-1:0] flag_set,
   input  logic             clr_we,
   input  logic             mask_we,
   input  logic [FLAGS-1:0] wdata,
   output logic [FLAGS-1:0] flags,
   output logic [FLAGS-1:0] mask,
   output logic             req
);

   logic [FLAGS-1:0] clr_bits;

   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= '0;
      end else begin
         flags <= (flags & ~clr_bits) | flag_set;
         if (mask_we) mask <= wdata;
      end
   end

   assign req = |(flags & mask);

endmodule

// File: rtl/irq_bus_decode.sv
// Address decode for the register port.
module irq_bus_decode
   import irq_cascade_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_CH = 2
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_en,
   output logic              rd_en,
   output logic              sel_sys_pend,
   output logic              sel_sys_mask,
   output logic              sel_pit,
   output logic              sel_per_pend,
   output logic              sel_per_mask,
   output logic [NUM_CH-1:0] sel_ch_flag,
   output logic [NUM_CH-1:0] sel_ch_mask
);

   assign wr_en = bus_valid &  bus_write;
   assign rd_en = bus_valid & ~bus_write;

   assign sel_sys_pend = (bus_addr == ADDR_W'(A_SYS_PEND));
   assign sel_sys_mask = (bus_addr == ADDR_W'(A_SYS_MASK));
   assign sel_pit      = (bus_addr == ADDR_W'(A_PIT_CTRL));
   assign sel_per_pend = (bus_addr == ADDR_W'(A_PER_PEND));
   assign sel_per_mask = (bus_addr == ADDR_W'(A_PER_MASK));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_dec
      assign sel_ch_flag[c] = (bus_addr == ADDR_W'(ch_flag_addr(c)));
      assign sel_ch_mask[c] = (bus_addr == ADDR_W'(ch_mask_addr(c)));
   end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irq_cascade_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int NUM_CH      = 2,
   parameter int CH_FLAGS    = 3,
   parameter int CASCADE_BIT = 24,
   parameter int PIT_BIT     = 30,
   parameter int PIT_KEY_BIT = 7,
   parameter int DMA_BIT_TOP = 21
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_valid,
   input  logic                       bus_write,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [DATA_W-1:0]          sys_set,
   input  logic [DATA_W-1:0]          per_set,
   input  logic [NUM_CH*CH_FLAGS-1:0] dma_set,
   output logic                       cpu_irq
);

   function automatic logic [DATA_W-1:0] dma_bit_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int c = 0; c < NUM_CH; c++) m[DMA_BIT_TOP-c] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] DMA_MASK  = dma_bit_mask();
   localparam logic [DATA_W-1:0] CASC_MASK = DATA_W'(1) << CASCADE_BIT;
   localparam logic [DATA_W-1:0] PIT_MASK  = DATA_W'(1) << PIT_BIT;

   // Elaboration-time parameter checks
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (CASCADE_BIT >= DATA_W || PIT_BIT >= DATA_W || PIT_KEY_BIT >= DATA_W) begin : g_bad_bit
      $error("cascade, timer or key bit outside the data width");
   end
   if (CH_FLAGS > DATA_W || CH_FLAGS < 1) begin : g_bad_flags
      $error("CH_FLAGS out of range");
   end
   if (NUM_CH < 1 || NUM_CH > 28 || DMA_BIT_TOP >= DATA_W || DMA_BIT_TOP - NUM_CH + 1 < 0) begin : g_bad_ch
      $error("channel count or channel bit placement out of range");
   end

   // Decode
   logic              wr_en, rd_en;
   logic              sel_sys_pend, sel_sys_mask, sel_pit, sel_per_pend, sel_per_mask;
   logic [NUM_CH-1:0] sel_ch_flag, sel_ch_mask;

   irq_bus_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .bus_valid    (bus_valid),
      .bus_write    (bus_write),
      .bus_addr     (bus_addr),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .sel_sys_pend (sel_sys_pend),
      .sel_sys_mask (sel_sys_mask),
      .sel_pit      (sel_pit),
      .sel_per_pend (sel_per_pend),
      .sel_per_mask (sel_per_mask),
      .sel_ch_flag  (sel_ch_flag),
      .sel_ch_mask  (sel_ch_mask)
   );

   // Channel level
   logic [CH_FLAGS-1:0] ch_flags [NUM_CH];
   logic [CH_FLAGS-1:0] ch_mask  [NUM_CH];
   logic [NUM_CH-1:0]   ch_req;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irq_dma_chan #(.FLAGS(CH_FLAGS)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .flag_set (dma_set[c*CH_FLAGS +: CH_FLAGS]),
         .clr_we   (wr_en & sel_ch_flag[c]),
         .mask_we  (wr_en & sel_ch_mask[c]),
         .wdata    (bus_wdata[CH_FLAGS-1:0]),
         .flags    (ch_flags[c]),
         .mask     (ch_mask[c]),
         .req      (ch_req[c])
      );
   end

   // Peripheral level
   logic [DATA_W-1:0] per_level, per_clr, per_pend, per_mask;
   logic              per_hit;

   always_comb begin
      per_level = '0;
      for (int c = 0; c < NUM_CH; c++) per_level[DMA_BIT_TOP-c] = ch_req[c];
   end

   assign per_clr = (wr_en & sel_per_pend) ? bus_wdata : '0;

   irq_pend_level #(.W(DATA_W), .LEVEL_MASK(DMA_MASK)) u_per (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_set     (per_set),
      .sw_clr     (per_clr),
      .level_in   (per_level),
      .mask_we    (wr_en & sel_per_mask),
      .mask_wdata (bus_wdata),
      .pend       (per_pend),
      .mask       (per_mask),
      .any_hit    (per_hit)
   );

   // System level
   logic [DATA_W-1:0] sys_level, sys_clr, sys_pend, sys_mask;
   logic              sys_hit;

   assign sys_level = per_hit ? CASC_MASK : '0;
   assign sys_clr   = (wr_en & sel_pit & bus_wdata[PIT_KEY_BIT]) ? PIT_MASK : '0;

   irq_pend_level #(.W(DATA_W), .LEVEL_MASK(CASC_MASK)) u_sys (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_set     (sys_set),
      .sw_clr     (sys_clr),
      .level_in   (sys_level),
      .mask_we    (wr_en & sel_sys_mask),
      .mask_wdata (bus_wdata),
      .pend       (sys_pend),
      .mask       (sys_mask),
      .any_hit    (sys_hit)
   );

   // Read mux
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (sel_sys_pend) rd_val = sys_pend;
      if (sel_sys_mask) rd_val = sys_mask;
      if (sel_per_pend) rd_val = per_pend;
      if (sel_per_mask) rd_val = per_mask;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel_ch_flag[c]) rd_val = DATA_W'(ch_flags[c]);
         if (sel_ch_mask[c]) rd_val = DATA_W'(ch_mask[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         cpu_irq   <= 1'b0;
      end else begin
         if (rd_en) bus_rdata <= rd_val;
         cpu_irq <= sys_hit;
      end
   end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
   import irq_cascade_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int NUM_CH      = 2,
   parameter int CASCADE_BIT = 24,
   parameter int PIT_BIT     = 30,
   parameter int PIT_KEY_BIT = 7,
   parameter int DMA_BIT_TOP = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] sys_set,
   input logic [DATA_W-1:0] per_set,
   input logic [DATA_W-1:0] sys_pend,
   input logic [DATA_W-1:0] sys_mask,
   input logic [DATA_W-1:0] per_pend,
   input logic              cpu_irq
);

   function automatic logic [DATA_W-1:0] chk_dma_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int c = 0; c < NUM_CH; c++) m[DMA_BIT_TOP-c] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] DMA_M  = chk_dma_mask();
   localparam logic [DATA_W-1:0] KEEP_M = ~(DATA_W'(1) << CASCADE_BIT);
   localparam int                MAP_END = int'(A_CH_BASE) + NUM_CH * int'(A_CH_STRIDE);

   logic pit_key_wr, unmapped_rd;
   assign pit_key_wr  = bus_valid && bus_write && (bus_addr == ADDR_W'(A_PIT_CTRL))
                        && bus_wdata[PIT_KEY_BIT];
   assign unmapped_rd = bus_valid && !bus_write && (int'(bus_addr) >= MAP_END);

   // R1
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !cpu_irq);

   // R2
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sys_pend & sys_mask)) |=> cpu_irq);

   // R2
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sys_pend & sys_mask)) |=> !cpu_irq);

   // R3
   sys_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pit_key_wr |=> (((sys_pend & KEEP_M) & $past(sys_pend & KEEP_M)) == $past(sys_pend & KEEP_M)));

   // R5
   pit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pit_key_wr && !sys_set[PIT_BIT]) |=> !sys_pend[PIT_BIT]);

   // R10
   per_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(per_set & ~DMA_M)) |=> ((per_pend & $past(per_set & ~DMA_M)) == $past(per_set & ~DMA_M)));

   // R11
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_rd |=> (bus_rdata == '0));

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CASCADE_BIT(CASCADE_BIT),
   .PIT_BIT(PIT_BIT), .PIT_KEY_BIT(PIT_KEY_BIT), .DMA_BIT_TOP(DMA_BIT_TOP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .sys_set(sys_set), .per_set(per_set), .sys_pend(sys_pend),
   .sys_mask(sys_mask), .per_pend(per_pend), .cpu_irq(cpu_irq)
);

// File: tb/irq_cascade_ctrl_test.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] sys_set = '0;
   logic [31:0] per_set = '0;
   logic [5:0]  dma_set = '0;
   logic        cpu_irq;

   int checks = 0;
   int fails  = 0;
   logic rd_issued = 1'b0;
   logic finished  = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   irq_cascade_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_set(sys_set), .per_set(per_set), .dma_set(dma_set), .cpu_irq(cpu_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares read data one edge after the strobe
   always @(posedge clk) begin
      #2;
      if (rd_issued) begin
         if (exp_q.size() == 0) chk("R11 unexpected read", bus_rdata, 32'hx);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_issued = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; rd_issued = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] s, input logic [31:0] p, input logic [5:0] dm);
      @(negedge clk);
      sys_set = s; per_set = p; dma_set = dm;
      @(negedge clk);
      sys_set = '0; per_set = '0; dma_set = '0;
   endtask

   // hardware set and bus write in the same cycle
   task automatic clash(input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] s, input logic [31:0] p, input logic [5:0] dm);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      sys_set = s; per_set = p; dma_set = dm;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      sys_set = '0; per_set = '0; dma_set = '0;
   endtask

   task automatic irq_is(input logic exp, input string tag);
      chk(tag, {31'b0, cpu_irq}, {31'b0, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      irq_is(1'b0, "R1 irq after reset");
      rd(8'h00, 32'h0, "R1 sys pend reset");
      rd(8'h04, 32'h0, "R1 sys mask reset");
      rd(8'h10, 32'h0, "R1 per pend reset");
      rd(8'h14, 32'h0, "R1 per mask reset");
      rd(8'h20, 32'h0, "R1 ch0 flags reset");
      rd(8'h2C, 32'h0, "R1 ch1 mask reset");

      // R3 mask read/write, pending read-only
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'hFFFF_FFFF, "R3 sys mask readback");
      wr(8'h00, 32'h0000_1234);
      rd(8'h00, 32'h0, "R3 sys pend write ignored");
      irq_is(1'b0, "R2 no pending no irq");

      // R4 / R2 set and one-cycle delay
      pulse(32'h0000_0003, '0, '0);
      irq_is(1'b0, "R2 irq not yet");
      @(negedge clk);
      irq_is(1'b1, "R2 irq one cycle later");
      rd(8'h00, 32'h0000_0003, "R4 sys pend sticky");
      pulse(32'h0100_0000, '0, '0);
      rd(8'h00, 32'h0000_0003, "R4 cascade bit not settable");
      wr(8'h04, 32'h0);
      irq_is(1'b1, "R2 irq held one cycle");
      @(negedge clk);
      irq_is(1'b0, "R2 irq dropped");

      // R5 timer clear
      pulse(32'h4000_0000, '0, '0);
      rd(8'h00, 32'h4000_0003, "R5 timer bit set");
      wr(8'h08, 32'h0000_007F);
      rd(8'h00, 32'h4000_0003, "R5 no key no clear");
      wr(8'h08, 32'h0000_0080);
      rd(8'h00, 32'h0000_0003, "R5 key clears bit 30");
      // R10 set beats timer clear
      clash(8'h08, 32'h0000_0080, 32'h4000_0000, '0, '0);
      rd(8'h00, 32'h4000_0003, "R10 timer set wins");
      wr(8'h08, 32'h0000_0080);

      // R6 / R7 peripheral level
      wr(8'h04, 32'h0100_0000);
      pulse('0, 32'h8000_0001, '0);
      rd(8'h10, 32'h8000_0001, "R7 per pend set");
      rd(8'h00, 32'h0000_0003, "R6 no cascade when masked");
      wr(8'h14, 32'h8000_0000);
      rd(8'h14, 32'h8000_0000, "R7 per mask replace");
      rd(8'h00, 32'h0100_0003, "R6 cascade bit set");
      irq_is(1'b1, "R2 irq via cascade");
      wr(8'h10, 32'h8000_0000);
      rd(8'h10, 32'h0000_0001, "R7 per pend w1c");
      rd(8'h00, 32'h0000_0003, "R6 cascade bit cleared");
      irq_is(1'b0, "R2 irq off via cascade");
      pulse('0, 32'h0030_0000, '0);
      rd(8'h10, 32'h0000_0001, "R9 channel bits not settable");
      clash(8'h10, 32'h0000_0005, '0, 32'h0000_0004, '0);
      rd(8'h10, 32'h0000_0004, "R10 per set wins");

      // R8 / R9 channel 0
      pulse('0, '0, 6'b000_011);
      rd(8'h20, 32'h0000_0003, "R8 ch0 flags set");
      rd(8'h10, 32'h0000_0004, "R9 ch0 masked off");
      wr(8'h24, 32'h0000_0002);
      rd(8'h24, 32'h0000_0002, "R8 ch0 mask readback");
      rd(8'h10, 32'h0020_0004, "R9 ch0 drives bit 21");
      wr(8'h14, 32'h0020_0000);
      rd(8'h00, 32'h0100_0003, "R6 cascade from channel");
      irq_is(1'b1, "R2 irq from channel");
      wr(8'h20, 32'h0000_0002);
      rd(8'h20, 32'h0000_0001, "R8 ch0 w1c");
      rd(8'h10, 32'h0000_0004, "R9 ch0 bit drops");
      rd(8'h00, 32'h0000_0003, "R6 cascade drops");
      irq_is(1'b0, "R2 irq off from channel");

      // R8 / R9 channel 1
      pulse('0, '0, 6'b100_000);
      rd(8'h28, 32'h0000_0004, "R8 ch1 flags set");
      wr(8'h2C, 32'h0000_0007);
      rd(8'h10, 32'h0010_0004, "R9 ch1 drives bit 20");
      wr(8'h10, 32'h0010_0000);
      rd(8'h10, 32'h0010_0004, "R9 bus clear ignored on channel bit");
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h28, 32'h0000_0000, "R8 ch1 all cleared");
      rd(8'h10, 32'h0000_0004, "R9 ch1 bit drops");
      clash(8'h28, 32'h0000_0001, '0, '0, 6'b001_000);
      rd(8'h28, 32'h0000_0001, "R10 channel set wins");
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h24, 32'h0000_0007, "R8 mask keeps three bits");
      rd(8'h10, 32'h0030_0004, "R9 both channel bits");
      rd(8'h00, 32'h0100_0003, "R6 cascade with both");

      // R11 unmapped
      wr(8'hF0, 32'hFFFF_FFFF);
      rd(8'hF0, 32'h0, "R11 unmapped read zero");
      rd(8'h04, 32'h0100_0000, "R11 unmapped write no effect");

      @(negedge clk);
      chk("R11 scoreboard drained", exp_q.size(), 32'd0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule